// File: doc/BRIEF.md
# Readout Protection Level Controller

This block keeps the active readout protection level of an embedded flash subsystem. It decodes an 8-bit protection byte held in option storage into one of three levels. From that level it drives the debug-enable line, the permissions for booting from RAM and from system memory, and a flag that limits option-byte writes to secure writes. A byte value that has been written only takes effect when the options are reloaded. A reload comes from a software launch pulse, from a wakeup out of a deep low-power mode, or from power-on reset. At power-on the byte is loaded directly after reset is released.

Lowering the level from 1 to 0 starts a wipe, and the level stays at 1 until the wipe has finished. A mode flag picks the kind of wipe:

- **Full wipe:** one mass-erase request to the flash.
- **Page wipe:** the flash pages are erased in ascending order, one request per page. Pages flagged as protected code are skipped.

Either way, the RAMs (both general SRAMs, the accelerator SRAM and the backup registers) are then erased. After that the saved option values are restored. Each memory target sits behind a request/acknowledge pair, and every request is held until its acknowledge arrives. The one-time-programmable area has no request line and is never touched.

Top module: `rdp_level_ctrl`

## Requirements
- R1: The level is decoded from the byte as follows: 0xAA gives level 0, 0xCC gives level 2, and any other value gives level 1. `level_o` encodes the level as 2'd0, 2'd1 and 2'd2.
- R2: A change of `prot_byte_i` does not change `level_o` or the access outputs until a reload. A reload is a one-cycle pulse on `reload_sw_i` or `reload_wake_i`, and its result is visible after the next rising clock edge. The first clock edge after `rst_ni` is released loads the byte as the power-on reload.
- R3: Level 2 can be entered from level 0 or from level 1. Once the level is 2, no reload changes it.
- R4: `debug_en_o` is 0 while `rst_ni` is low and whenever the level is 2. `boot_ram_ok_o` and `boot_sys_ok_o` are 0 in level 2 and 1 otherwise. `opt_secure_only_o` is 1 only in level 2.
- R5: Erase and restore requests are raised only for a reload that requests level 0 while the level is 1. Reloads that keep or raise the level (0→1, 1→2, 0→2) raise no request and leave `busy_o` low.
- R6: With `code_wipe_i`=1 at the reload, the block issues exactly one `mass_req_o`, then one `ram_req_o`, then one `restore_req_o`. `code_prot_clr_o` is high together with `restore_req_o`.
- R7: With `code_wipe_i`=0 at the reload, `page_req_o` is issued once for each page p whose bit `page_prot_i[p]` is 0, in ascending page order, with the page number on `page_idx_o`. Protected pages are skipped. Then one `ram_req_o` and one `restore_req_o` follow, with `code_prot_clr_o` low.
- R8: `restore_req_o` is raised only after the flash erase has finished. In the cycle after the restore acknowledge, `level_o` is 0, `busy_o` is low and `done_o` pulses for one cycle.
- R9: `busy_o` is high from the cycle after the regression reload until the restore acknowledge. While it is high the level stays 1, and any reload is ignored.
- R10: At most one request output is high at a time. A request stays high, with `page_idx_o` stable, until its acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| prot_byte_i | input | 8 | Programmed protection byte from option storage |
| code_wipe_i | input | 1 | 1: full mass erase on regression; 0: page-by-page erase |
| page_prot_i | input | NUM_PAGES | Per-page protected-code flags |
| reload_sw_i | input | 1 | Software option-reload pulse |
| reload_wake_i | input | 1 | Low-power wakeup reload pulse |
| mass_ack_i | input | 1 | Flash mass-erase acknowledge |
| page_ack_i | input | 1 | Flash page-erase acknowledge |
| ram_ack_i | input | 1 | RAM and backup-register erase acknowledge |
| restore_ack_i | input | 1 | Option-restore acknowledge |
| level_o | output | 2 | Active protection level |
| debug_en_o | output | 1 | Debug port enable |
| boot_ram_ok_o | output | 1 | Boot from RAM permitted |
| boot_sys_ok_o | output | 1 | Boot from system memory permitted |
| opt_secure_only_o | output | 1 | Option bytes accept only reads and secure writes |
| mass_req_o | output | 1 | Flash mass-erase request |
| page_req_o | output | 1 | Flash page-erase request |
| page_idx_o | output | $clog2(NUM_PAGES) | Page number of the page-erase request |
| ram_req_o | output | 1 | RAM and backup-register erase request |
| restore_req_o | output | 1 | Option-restore request |
| code_prot_clr_o | output | 1 | Disable code-region protection along with the restore |
| busy_o | output | 1 | Wipe sequence in progress |
| done_o | output | 1 | One-cycle pulse when the wipe has completed |

## Verification
The regression wipe is run with the full-wipe flag set and with it clear. The page masks used are:

- none protected, which shows that every page is visited;
- all protected, which shows that the walk ends without issuing a request;
- only the end pages protected, which exposes off-by-one errors at both ends of the walk;
- random masks.

Each run compares the recorded request order against a list built from the mask, so a skipped page, an extra page, or a RAM erase or restore issued too early all show up. Level changes are tried over every transition between levels, including level 2 with every kind of byte, plus a reload injected during a wipe. This separates erase-triggering reloads from raising reloads, and separates sticky level 2 from ordinary level updates.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

   typedef enum logic [1:0] {
      LVL0 = 2'd0,
      LVL1 = 2'd1,
      LVL2 = 2'd2
   } rdp_level_e;

   typedef enum logic [2:0] {
      SEQ_IDLE    = 3'd0,
      SEQ_MASS    = 3'd1,
      SEQ_PAGE    = 3'd2,
      SEQ_RAM     = 3'd3,
      SEQ_RESTORE = 3'd4
   } seq_state_e;

endpackage

// File: rtl/rdp_access_gate.sv
module rdp_access_gate
   import rdp_pkg::*;
(
   input  logic       rst_ni,
   input  rdp_level_e level_i,
   output logic       debug_en_o,
   output logic       boot_ram_ok_o,
   output logic       boot_sys_ok_o,
   output logic       opt_secure_only_o
);

   logic locked;

   assign locked            = (level_i == LVL2);
   // debug stays off for the whole reset phase, whatever the level
   assign debug_en_o        = rst_ni && !locked;
   assign boot_ram_ok_o     = !locked;
   assign boot_sys_ok_o     = !locked;
   assign opt_secure_only_o = locked;

endmodule

// File: rtl/rdp_page_walker.sv
module rdp_page_walker #(
   parameter int NUM_PAGES = 16,
   parameter bit FAST_SKIP = 1'b1,
   localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 start_i,
   input  logic [NUM_PAGES-1:0] prot_i,
   input  logic                 ack_i,
   output logic                 req_o,
   output logic [IDX_W-1:0]     idx_o,
   output logic                 active_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAGES - 1);

   logic [IDX_W-1:0] idx_q;
   logic             act_q;

   generate
      if (FAST_SKIP) begin : g_fast
         // jump straight to the next unprotected page, no idle cycles
         logic             hit_first, hit_next;
         logic [IDX_W-1:0] pos_first, pos_next;

         always_comb begin
            hit_first = 1'b0;
            hit_next  = 1'b0;
            pos_first = '0;
            pos_next  = '0;
            for (int j = NUM_PAGES - 1; j >= 0; j--) begin
               if (!prot_i[j]) begin
                  hit_first = 1'b1;
                  pos_first = IDX_W'(j);
               end
               if (!prot_i[j] && (j > int'(idx_q))) begin
                  hit_next = 1'b1;
                  pos_next = IDX_W'(j);
               end
            end
         end

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               act_q <= 1'b0;
               idx_q <= '0;
            end else if (start_i) begin
               act_q <= hit_first;
               idx_q <= pos_first;
            end else if (act_q && ack_i) begin
               act_q <= hit_next;
               if (hit_next) idx_q <= pos_next;
            end
         end

         assign req_o = act_q;
      end else begin : g_step
         // one page per cycle; protected pages cost a cycle each
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               act_q <= 1'b0;
               idx_q <= '0;
            end else if (start_i) begin
               act_q <= 1'b1;
               idx_q <= '0;
            end else if (act_q && (prot_i[idx_q] || ack_i)) begin
               if (idx_q == LAST_IDX) act_q <= 1'b0;
               else                   idx_q <= idx_q + 1'b1;
            end
         end

         assign req_o = act_q && !prot_i[idx_q];
      end
   endgenerate

   assign idx_o    = idx_q;
   assign active_o = act_q;

endmodule

// File: rtl/rdp_wipe_seq.sv
module rdp_wipe_seq
   import rdp_pkg::*;
#(
   parameter int NUM_PAGES = 16,
   parameter bit FAST_SKIP = 1'b1,
   localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 start_i,
   input  logic                 full_i,
   input  logic [NUM_PAGES-1:0] page_prot_i,
   input  logic                 mass_ack_i,
   input  logic                 page_ack_i,
   input  logic                 ram_ack_i,
   input  logic                 restore_ack_i,
   output logic                 mass_req_o,
   output logic                 page_req_o,
   output logic [IDX_W-1:0]     page_idx_o,
   output logic                 ram_req_o,
   output logic                 restore_req_o,
   output logic                 code_prot_clr_o,
   output logic                 busy_o,
   output logic                 fin_o
);

   seq_state_e           state_q, state_d;
   logic                 full_q;
   logic [NUM_PAGES-1:0] prot_q;
   logic [NUM_PAGES-1:0] prot_eff;
   logic                 walk_start, walk_req, walk_act;
   logic                 accept;

   assign accept     = (state_q == SEQ_IDLE) && start_i;
   assign walk_start = accept && !full_i;
   // walker needs the mask in the start cycle, before the snapshot lands
   assign prot_eff   = (state_q == SEQ_IDLE) ? page_prot_i : prot_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SEQ_IDLE;
         full_q  <= 1'b0;
         prot_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            full_q <= full_i;
            prot_q <= page_prot_i;
         end
      end
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE:    if (start_i) state_d = full_i ? SEQ_MASS : SEQ_PAGE;
         SEQ_MASS:    if (mass_ack_i) state_d = SEQ_RAM;
         SEQ_PAGE:    if (!walk_act) state_d = SEQ_RAM;
         SEQ_RAM:     if (ram_ack_i) state_d = SEQ_RESTORE;
         SEQ_RESTORE: if (restore_ack_i) state_d = SEQ_IDLE;
         default:     state_d = SEQ_IDLE;
      endcase
   end

   rdp_page_walker #(
      .NUM_PAGES (NUM_PAGES),
      .FAST_SKIP (FAST_SKIP)
   ) u_walker (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (walk_start),
      .prot_i   (prot_eff),
      .ack_i    (page_ack_i && page_req_o),
      .req_o    (walk_req),
      .idx_o    (page_idx_o),
      .active_o (walk_act)
   );

   assign mass_req_o      = (state_q == SEQ_MASS);
   assign page_req_o      = (state_q == SEQ_PAGE) && walk_req;
   assign ram_req_o       = (state_q == SEQ_RAM);
   assign restore_req_o   = (state_q == SEQ_RESTORE);
   assign code_prot_clr_o = (state_q == SEQ_RESTORE) && full_q;
   assign busy_o          = (state_q != SEQ_IDLE);
   assign fin_o           = (state_q == SEQ_RESTORE) && restore_ack_i;

endmodule

// File: rtl/rdp_level_ctrl.sv
module rdp_level_ctrl
   import rdp_pkg::*;
#(
   parameter int         NUM_PAGES = 16,
   parameter bit         FAST_SKIP = 1'b1,
   parameter logic [7:0] OPEN_CODE = 8'hAA,
   parameter logic [7:0] LOCK_CODE = 8'hCC,
   localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [7:0]           prot_byte_i,
   input  logic                 code_wipe_i,
   input  logic [NUM_PAGES-1:0] page_prot_i,
   input  logic                 reload_sw_i,
   input  logic                 reload_wake_i,
   input  logic                 mass_ack_i,
   input  logic                 page_ack_i,
   input  logic                 ram_ack_i,
   input  logic                 restore_ack_i,
   output logic [1:0]           level_o,
   output logic                 debug_en_o,
   output logic                 boot_ram_ok_o,
   output logic                 boot_sys_ok_o,
   output logic                 opt_secure_only_o,
   output logic                 mass_req_o,
   output logic                 page_req_o,
   output logic [IDX_W-1:0]     page_idx_o,
   output logic                 ram_req_o,
   output logic                 restore_req_o,
   output logic                 code_prot_clr_o,
   output logic                 busy_o,
   output logic                 done_o
);

   generate
      if (NUM_PAGES < 2) begin : g_chk_pages
         $error("rdp_level_ctrl: NUM_PAGES must be at least 2");
      end
      if (OPEN_CODE == LOCK_CODE) begin : g_chk_codes
         $error("rdp_level_ctrl: OPEN_CODE and LOCK_CODE must differ");
      end
   endgenerate

   rdp_level_e level_q, req_lvl;
   logic       por_pend_q;
   logic       run_reload;
   logic       start_wipe;
   logic       wipe_fin;
   logic       seq_busy;

   always_comb begin
      if (prot_byte_i == OPEN_CODE)      req_lvl = LVL0;
      else if (prot_byte_i == LOCK_CODE) req_lvl = LVL2;
      else                               req_lvl = LVL1;
   end

   assign run_reload = (reload_sw_i || reload_wake_i) && !seq_busy && !por_pend_q;
   assign start_wipe = run_reload && (level_q == LVL1) && (req_lvl == LVL0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         level_q    <= LVL2;   // most restrictive until the byte is loaded
         por_pend_q <= 1'b1;
         done_o     <= 1'b0;
      end else begin
         por_pend_q <= 1'b0;
         done_o     <= 1'b0;
         if (wipe_fin) begin
            level_q <= LVL0;
            done_o  <= 1'b1;
         end else if (por_pend_q) begin
            level_q <= req_lvl;
         end else if (run_reload && (level_q != LVL2) && !start_wipe) begin
            level_q <= req_lvl;
         end
      end
   end

   rdp_wipe_seq #(
      .NUM_PAGES (NUM_PAGES),
      .FAST_SKIP (FAST_SKIP)
   ) u_seq (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .start_i         (start_wipe),
      .full_i          (code_wipe_i),
      .page_prot_i     (page_prot_i),
      .mass_ack_i      (mass_ack_i),
      .page_ack_i      (page_ack_i),
      .ram_ack_i       (ram_ack_i),
      .restore_ack_i   (restore_ack_i),
      .mass_req_o      (mass_req_o),
      .page_req_o      (page_req_o),
      .page_idx_o      (page_idx_o),
      .ram_req_o       (ram_req_o),
      .restore_req_o   (restore_req_o),
      .code_prot_clr_o (code_prot_clr_o),
      .busy_o          (seq_busy),
      .fin_o           (wipe_fin)
   );

   rdp_access_gate u_gate (
      .rst_ni            (rst_ni),
      .level_i           (level_q),
      .debug_en_o        (debug_en_o),
      .boot_ram_ok_o     (boot_ram_ok_o),
      .boot_sys_ok_o     (boot_sys_ok_o),
      .opt_secure_only_o (opt_secure_only_o)
   );

   assign level_o = level_q;
   assign busy_o  = seq_busy;

endmodule

// File: rtl/rdp_level_ctrl_chk.sv
module rdp_level_ctrl_chk #(
   parameter int NUM_PAGES = 16,
   localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             page_ack_i,
   input logic [1:0]       level_o,
   input logic             debug_en_o,
   input logic             mass_req_o,
   input logic             page_req_o,
   input logic [IDX_W-1:0] page_idx_o,
   input logic             ram_req_o,
   input logic             restore_req_o,
   input logic             code_prot_clr_o,
   input logic             busy_o,
   input logic             done_o
);

   logic armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed_q <= 1'b0;
      else         armed_q <= 1'b1;
   end

   // R3: level 2 is permanent once the power-on load has happened
   assert_l2_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && level_o == 2'd2) |=> (level_o == 2'd2));

   // R4: debug port closed in level 2
   assert_debug_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_o == 2'd2) |-> !debug_en_o);

   // R4: debug port closed during reset
   always_comb begin
      if (rst_ni === 1'b0) begin
         assert_debug_reset_R4: assert (debug_en_o !== 1'b1);
      end
   end

   // R5: no request outside a wipe
   assert_req_in_wipe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mass_req_o || page_req_o || ram_req_o || restore_req_o) |-> busy_o);

   // R6: code-protection clear only alongside the restore
   assert_clr_with_restore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_prot_clr_o |-> restore_req_o);

   // R8: completion leaves level 0 and idle
   assert_done_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (level_o == 2'd0 && !busy_o));

   // R9: level held at 1 during the wipe
   assert_busy_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (level_o == 2'd1));

   // R10: one request at a time
   assert_req_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({mass_req_o, page_req_o, ram_req_o, restore_req_o}));

   // R10: page request held with stable index until acknowledged
   assert_page_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (page_req_o && !page_ack_i) |=> (page_req_o && $stable(page_idx_o)));

endmodule

bind rdp_level_ctrl rdp_level_ctrl_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .page_ack_i      (page_ack_i),
   .level_o         (level_o),
   .debug_en_o      (debug_en_o),
   .mass_req_o      (mass_req_o),
   .page_req_o      (page_req_o),
   .page_idx_o      (page_idx_o),
   .ram_req_o       (ram_req_o),
   .restore_req_o   (restore_req_o),
   .code_prot_clr_o (code_prot_clr_o),
   .busy_o          (busy_o),
   .done_o          (done_o)
);

// File: tb/rdp_level_ctrl_tb.sv
`timescale 1ns/1ps
module rdp_level_ctrl_tb;

   localparam int NP = 16;
   localparam int IW = $clog2(NP);
   localparam int EV_MASS = 1, EV_PAGE = 2, EV_RAM = 3, EV_REST = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [7:0]    prot_byte;
   logic          code_wipe;
   logic [NP-1:0] page_prot;
   logic          reload_sw, reload_wake;
   logic          mass_ack, page_ack, ram_ack, restore_ack;
   logic [1:0]    level;
   logic          debug_en, boot_ram_ok, boot_sys_ok, opt_sec;
   logic          mass_req, page_req, ram_req, restore_req, clr, busy, done;
   logic [IW-1:0] page_idx;

   int tests = 0, fails = 0;
   int ev_n = 0;
   int ev_kind [64];
   int ev_arg  [64];
   bit finished = 1'b0;

   always #2 clk = ~clk;

   rdp_level_ctrl #(.NUM_PAGES(NP)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .prot_byte_i(prot_byte), .code_wipe_i(code_wipe),
      .page_prot_i(page_prot), .reload_sw_i(reload_sw), .reload_wake_i(reload_wake),
      .mass_ack_i(mass_ack), .page_ack_i(page_ack), .ram_ack_i(ram_ack),
      .restore_ack_i(restore_ack), .level_o(level), .debug_en_o(debug_en),
      .boot_ram_ok_o(boot_ram_ok), .boot_sys_ok_o(boot_sys_ok), .opt_secure_only_o(opt_sec),
      .mass_req_o(mass_req), .page_req_o(page_req), .page_idx_o(page_idx),
      .ram_req_o(ram_req), .restore_req_o(restore_req), .code_prot_clr_o(clr),
      .busy_o(busy), .done_o(done));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void log_ev(input int kind, input int arg);
      if (ev_n < 64) begin
         ev_kind[ev_n] = kind;
         ev_arg[ev_n]  = arg;
      end
      ev_n++;
   endfunction

   // targets: random latency acknowledge, one-cycle pulse, logged on raise
   always @(negedge clk) begin
      if (mass_ack) mass_ack <= 1'b0;
      else if (mass_req && ($urandom % 2 == 0)) begin
         mass_ack <= 1'b1; log_ev(EV_MASS, 0);
      end
      if (page_ack) page_ack <= 1'b0;
      else if (page_req && ($urandom % 2 == 0)) begin
         page_ack <= 1'b1; log_ev(EV_PAGE, int'(page_idx));
      end
      if (ram_ack) ram_ack <= 1'b0;
      else if (ram_req && ($urandom % 2 == 0)) begin
         ram_ack <= 1'b1; log_ev(EV_RAM, 0);
      end
      if (restore_ack) restore_ack <= 1'b0;
      else if (restore_req && ($urandom % 2 == 0)) begin
         restore_ack <= 1'b1; log_ev(EV_REST, int'(clr));
      end
   end

   task automatic pulse_reload(input bit wake);
      @(negedge clk);
      if (wake) reload_wake = 1'b1; else reload_sw = 1'b1;
      @(negedge clk);
      reload_sw = 1'b0; reload_wake = 1'b0;
   endtask

   task automatic check_access(input int lvl, input string req);
      chk(int'(level) == lvl, {req, " level"}, level, lvl);
      chk(debug_en == (lvl != 2), "R4 debug_en", debug_en, lvl != 2);
      chk(boot_ram_ok == (lvl != 2) && boot_sys_ok == (lvl != 2), "R4 boot permits",
          {boot_ram_ok, boot_sys_ok}, (lvl != 2) ? 3 : 0);
      chk(opt_sec == (lvl == 2), "R4 secure-only", opt_sec, lvl == 2);
   endtask

   // reload that must not start a wipe
   task automatic plain_reload(input logic [7:0] b, input int exp_lvl, input string req);
      @(negedge clk); prot_byte = b; ev_n = 0;
      pulse_reload($urandom % 2);
      chk(!busy, {req, " busy stays low"}, busy, 0);
      repeat (4) @(negedge clk);
      chk(ev_n == 0, "R5 no erase on non-regression", ev_n, 0);
      check_access(exp_lvl, req);
   endtask

   task automatic regress(input bit full, input logic [NP-1:0] mask, input bit inject);
      int exp_kind [64];
      int exp_arg  [64];
      int exp_n = 0, cnt = 0, gap = 0, lvl_bad = 0;
      if (full) begin
         exp_kind[0] = EV_MASS; exp_arg[0] = 0; exp_n = 1;
      end else begin
         for (int p = 0; p < NP; p++)
            if (!mask[p]) begin exp_kind[exp_n] = EV_PAGE; exp_arg[exp_n] = p; exp_n++; end
      end
      exp_kind[exp_n] = EV_RAM;  exp_arg[exp_n] = 0;         exp_n++;
      exp_kind[exp_n] = EV_REST; exp_arg[exp_n] = int'(full); exp_n++;

      @(negedge clk); code_wipe = full; page_prot = mask; prot_byte = 8'hAA; ev_n = 0;
      pulse_reload($urandom % 2);
      chk(busy, "R9 busy after regression reload", busy, 1);
      while (!done && cnt < 3000) begin
         if (!busy) gap++;
         if (level != 2'd1) lvl_bad++;
         if (inject && cnt == 2) begin prot_byte = 8'hCC; reload_sw = 1'b1; end
         if (inject && cnt == 3) begin reload_sw = 1'b0; prot_byte = 8'hAA; end
         @(negedge clk); cnt++;
      end
      chk(done, "R8 done pulse seen", done, 1);
      chk(gap == 0, "R9 busy continuous", gap, 0);
      chk(lvl_bad == 0, "R9 level held at 1", lvl_bad, 0);
      chk(int'(level) == 0 && !busy, "R8 level 0 after wipe", level, 0);
      chk(ev_n == exp_n, full ? "R6 request count" : "R7 request count", ev_n, exp_n);
      for (int k = 0; k < exp_n && k < ev_n; k++) begin
         chk(ev_kind[k] == exp_kind[k],
             (k == exp_n - 1) ? "R8 restore last" : (full ? "R6 order" : "R7 order"),
             ev_kind[k], exp_kind[k]);
         chk(ev_arg[k] == exp_arg[k],
             (exp_kind[k] == EV_REST) ? "R6 code clear flag" : "R7 page number",
             ev_arg[k], exp_arg[k]);
      end
      @(negedge clk);
      chk(!done, "R8 done single cycle", done, 0);
      if (inject) chk(int'(level) == 0, "R9 reload during wipe ignored", level, 0);
   endtask

   initial begin
      int seed_set;
      seed_set = $urandom(32'h5eed_0461);
      rst_n = 1'b0; prot_byte = 8'hAA; code_wipe = 1'b0; page_prot = '0;
      reload_sw = 1'b0; reload_wake = 1'b0;
      mass_ack = 1'b0; page_ack = 1'b0; ram_ack = 1'b0; restore_ack = 1'b0;
      repeat (3) @(negedge clk);
      chk(!debug_en, "R4 debug off in reset", debug_en, 0);
      chk(!busy && !mass_req && !page_req, "R5 idle in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_access(0, "R1 power-on load 0xAA");

      // R2: written byte without reload has no effect
      prot_byte = 8'h33;
      repeat (5) @(negedge clk);
      check_access(0, "R2 no reload no change");
      plain_reload(8'h33, 1, "R2 R1 reload to level 1");

      // directed wipes
      regress(1'b1, 16'h0F0F, 1'b0);
      plain_reload(8'h00, 1, "R5 raise 0 to 1");
      regress(1'b0, 16'h0000, 1'b0);
      plain_reload(8'hFF, 1, "R1 0xFF is level 1");
      regress(1'b0, 16'hFFFF, 1'b0);
      plain_reload(8'hAB, 1, "R1 0xAB is level 1");
      regress(1'b0, 16'h8001, 1'b1);
      plain_reload(8'h55, 1, "R1 0x55 is level 1");

      // random wipes
      for (int r = 0; r < 8; r++) begin
         logic [7:0] b;
         regress($urandom % 2, NP'($urandom), ($urandom % 3) == 0);
         b = 8'($urandom);
         if (b == 8'hAA || b == 8'hCC) b = 8'h11;
         plain_reload(b, 1, "R1 random byte level 1");
      end

      // 1 -> 2, then sticky
      plain_reload(8'hCC, 2, "R3 raise 1 to 2");
      plain_reload(8'hAA, 2, "R3 level 2 ignores 0xAA");
      plain_reload(8'h3C, 2, "R3 level 2 ignores level-1 byte");

      // power-on with locked byte
      @(negedge clk); rst_n = 1'b0; prot_byte = 8'hCC;
      repeat (2) @(negedge clk);
      chk(!debug_en, "R4 debug off in reset at level 2", debug_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_access(2, "R3 power-on load level 2");

      // 0 -> 2 directly
      @(negedge clk); rst_n = 1'b0; prot_byte = 8'hAA;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_access(0, "R1 power-on level 0");
      plain_reload(8'hCC, 2, "R3 raise 0 to 2");

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule